// File: doc/BRIEF.md
# Halfword Signed Multiply-Accumulate Unit

This unit performs signed DSP multiplies in which each operand can be narrowed to one of its two 16-bit halves. It supports five operations: a 16x16 product, with or without a 32-bit addend; a 16x16 product added into a 64-bit accumulator; and a 32x16 product reduced to its upper 32 bits, with or without a 32-bit addend. A caller presents both operands, the accumulator words, two half-select bits, an operation code and a valid strobe for one cycle. The result appears on the next cycle together with an output strobe.

A sticky overflow flag records any signed overflow caused by the two 32-bit accumulate operations. The flag stays set until software-visible logic pulses the clear input. Arithmetic results wrap modulo 2^32 or 2^64 and never saturate.

Top module: `hmac_unit`

## Requirements
- R1: Opcode 0 returns resLo = selA * selB + accLo, wrapped to 32 bits, with resHi = 0. selA is opA[31:16] when xTop=1 and opA[15:0] when xTop=0. selB is taken from opB under yTop in the same way. Both halves are signed.
- R2: Opcode 1 returns {resHi,resLo} = {accHi,accLo} + the sign-extended selA * selB, wrapped to 64 bits.
- R3: Opcode 2 returns resLo = bits [47:16] of the signed 48-bit product opA * selB, plus accLo, wrapped to 32 bits, with resHi = 0. This is an arithmetic shift right by 16.
- R4: Opcode 3 returns resLo = selA * selB as a signed 32-bit value, with resHi = 0.
- R5: Opcode 4 returns resLo = bits [47:16] of the signed product opA * selB, with resHi = 0.
- R6: Opcodes 5 to 7 are ignored. They produce no output strobe, leave resLo and resHi unchanged, and do not touch the flag.
- R7: outValid is high in exactly the cycle after a cycle in which inValid was high with a legal opcode. resLo and resHi change only at that edge and hold their values otherwise.
- R8: qFlag becomes set at that same edge when the 32-bit addition of opcode 0 or opcode 2 overflows as a signed value.
- R9: Opcodes 1, 3 and 4 never set qFlag.
- R10: qFlag is sticky and is cleared only by qClear. If a clear and an overflow occur at the same edge, the flag ends set.
- R11: After reset, outValid, resLo, resHi and qFlag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opSel | input | 3 | Operation code (0..4 legal) |
| xTop | input | 1 | Select upper half of opA |
| yTop | input | 1 | Select upper half of opB |
| opA | input | 32 | First multiplicand |
| opB | input | 32 | Second multiplicand |
| accLo | input | 32 | Accumulator low word / 32-bit addend |
| accHi | input | 32 | Accumulator high word |
| qClear | input | 1 | Clear overflow flag |
| outValid | output | 1 | Result strobe |
| resLo | output | 32 | Result low word |
| resHi | output | 32 | Result high word (zero for 32-bit forms) |
| qFlag | output | 1 | Sticky overflow flag |

## Verification
Every result, the output strobe and the overflow flag are due exactly one clock edge after the request is sampled. The bench drives each request on a falling edge and compares all four outputs on the next falling edge, which is half a cycle after the capturing edge. It deasserts the request before the following edge, so every hold and ignore case can be observed on its own cycle. The expected flag is carried forward in the bench across operations, which lets the sticky and clear behaviour be compared on every cycle.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
  typedef enum logic [2:0] {
    OP_MLA16  = 3'd0,
    OP_MLAL16 = 3'd1,
    OP_MLAW   = 3'd2,
    OP_MUL16  = 3'd3,
    OP_MULW   = 3'd4
  } hmacOp_t;

  typedef struct packed {
    logic capture;
    logic accumulate;
    logic longForm;
    logic wideOp;
    logic ovfEnable;
  } hmacStrb_t;
endpackage

// File: rtl/hmac_ctrl.sv
module hmac_ctrl
  import hmac_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic [2:0] opSel,
  input  logic      qClear,
  input  logic      ovfHit,
  output hmacStrb_t strb,
  output logic      outValid,
  output logic      qFlag
);
  always_comb begin
    strb = '0;
    case (hmacOp_t'(opSel))
      OP_MLA16:  strb = '{capture: inValid, accumulate: 1'b1, longForm: 1'b0, wideOp: 1'b0, ovfEnable: 1'b1};
      OP_MLAL16: strb = '{capture: inValid, accumulate: 1'b1, longForm: 1'b1, wideOp: 1'b0, ovfEnable: 1'b0};
      OP_MLAW:   strb = '{capture: inValid, accumulate: 1'b1, longForm: 1'b0, wideOp: 1'b1, ovfEnable: 1'b1};
      OP_MUL16:  strb = '{capture: inValid, accumulate: 1'b0, longForm: 1'b0, wideOp: 1'b0, ovfEnable: 1'b0};
      OP_MULW:   strb = '{capture: inValid, accumulate: 1'b0, longForm: 1'b0, wideOp: 1'b1, ovfEnable: 1'b0};
      default:   strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      qFlag    <= 1'b0;
    end else begin
      outValid <= strb.capture;
      qFlag    <= (qFlag & ~qClear) | ovfHit;
    end
  end

  // R7
  out_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> outValid);
  // R6
  no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> !outValid);
  // R10
  q_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qFlag && !qClear) |=> qFlag);
  // R10
  q_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qClear && !ovfHit) |=> !qFlag);
  // R9
  q_only_acc32_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!qFlag && !(strb.capture && strb.ovfEnable)) |=> !qFlag);
endmodule

// File: rtl/hmac_dp.sv
module hmac_dp
  import hmac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  hmacStrb_t         strb,
  input  logic              xTop,
  input  logic              yTop,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] accLo,
  input  logic [DATA_W-1:0] accHi,
  output logic              ovfHit,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi
);
  localparam int HALF_W = DATA_W / 2;
  localparam int WIDE_W = DATA_W + HALF_W;
  localparam int LONG_W = 2 * DATA_W;

  logic signed [HALF_W-1:0] halfA, halfB;
  logic signed [DATA_W-1:0] prodHalf, prodWord, prodSel, addend, sum32;
  logic signed [WIDE_W-1:0] prodFull;
  logic [LONG_W-1:0]        sum64;
  logic                     rawOvf;

  assign halfA    = xTop ? opA[DATA_W-1:HALF_W] : opA[HALF_W-1:0];
  assign halfB    = yTop ? opB[DATA_W-1:HALF_W] : opB[HALF_W-1:0];
  assign prodHalf = halfA * halfB;
  assign prodFull = $signed(opA) * halfB;
  assign prodWord = DATA_W'(prodFull >>> HALF_W);
  assign prodSel  = strb.wideOp ? prodWord : prodHalf;
  assign addend   = strb.accumulate ? $signed(accLo) : '0;
  assign sum32    = prodSel + addend;
  assign sum64    = {accHi, accLo} + LONG_W'(prodHalf);
  assign rawOvf   = (prodSel[DATA_W-1] == addend[DATA_W-1]) &&
                    (sum32[DATA_W-1] != prodSel[DATA_W-1]);
  assign ovfHit   = strb.capture & strb.ovfEnable & rawOvf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resLo <= '0;
      resHi <= '0;
    end else if (strb.capture) begin
      resLo <= strb.longForm ? sum64[DATA_W-1:0] : sum32;
      resHi <= strb.longForm ? sum64[LONG_W-1:DATA_W] : '0;
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(resLo) && $stable(resHi)));
  // R1
  short_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.longForm) |=> (resHi == '0));
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
  import hmac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        opSel,
  input  logic              xTop,
  input  logic              yTop,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] accLo,
  input  logic [DATA_W-1:0] accHi,
  input  logic              qClear,
  output logic              outValid,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi,
  output logic              qFlag
);
  hmacStrb_t strb;
  logic      ovfHit;

  hmac_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .qClear(qClear),
    .ovfHit(ovfHit), .strb(strb), .outValid(outValid), .qFlag(qFlag)
  );

  hmac_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .xTop(xTop), .yTop(yTop),
    .opA(opA), .opB(opB), .accLo(accLo), .accHi(accHi),
    .ovfHit(ovfHit), .resLo(resLo), .resHi(resHi)
  );
endmodule

// File: tb/hmac_unit_tb_top.sv
module hmac_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, xTop = 1'b0, yTop = 1'b0, qClear = 1'b0;
  logic [2:0] opSel = '0;
  logic [31:0] opA = '0, opB = '0, accLo = '0, accHi = '0;
  logic outValid, qFlag;
  logic [31:0] resLo, resHi;

  int compared = 0, mismatched = 0;
  logic qExp = 1'b0;
  logic [31:0] lastLo = '0, lastHi = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hmac_unit dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic x, input logic y,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] lo, input logic [31:0] hi,
                                output logic [31:0] eLo, output logic [31:0] eHi, output logic eOvf);
    logic signed [63:0] ha, hb, p16, pw, add, s;
    ha  = 64'($signed(x ? a[31:16] : a[15:0]));
    hb  = 64'($signed(y ? b[31:16] : b[15:0]));
    p16 = ha * hb;
    pw  = (64'($signed(a)) * hb) >>> 16;
    add = 64'($signed(lo));
    eHi = 0; eOvf = 0;
    case (op)
      3'd0: begin s = p16 + add; eLo = s[31:0]; eOvf = (s > 64'sh7fffffff) || (s < -64'sh80000000); end
      3'd1: begin s = p16 + $signed({hi, lo}); eLo = s[31:0]; eHi = s[63:32]; end
      3'd2: begin s = pw + add; eLo = s[31:0]; eOvf = (s > 64'sh7fffffff) || (s < -64'sh80000000); end
      3'd3: eLo = p16[31:0];
      default: eLo = pw[31:0];
    endcase
  endfunction

  // Called at a falling edge; checks on the next falling edge.
  task automatic doOp(input logic [2:0] op, input logic x, input logic y,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] lo, input logic [31:0] hi, input logic clr, input string tag);
    logic [31:0] eLo, eHi; logic eOvf; bit legal;
    legal = (op <= 3'd4);
    if (legal) model(op, x, y, a, b, lo, hi, eLo, eHi, eOvf);
    else begin eLo = lastLo; eHi = lastHi; eOvf = 1'b0; end
    inValid = 1'b1; opSel = op; xTop = x; yTop = y; opA = a; opB = b;
    accLo = lo; accHi = hi; qClear = clr;
    @(negedge clk);
    qExp = (qExp & ~clr) | eOvf;
    chk(outValid == legal, {tag, " valid R7"}, 64'(outValid), 64'(legal));
    chk(resLo == eLo, {tag, " lo"}, 64'(resLo), 64'(eLo));
    chk(resHi == eHi, {tag, " hi"}, 64'(resHi), 64'(eHi));
    chk(qFlag == qExp, {tag, " q R8 R9 R10"}, 64'(qFlag), 64'(qExp));
    lastLo = eLo; lastHi = eHi;
    inValid = 1'b0; qClear = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11
    chk(!outValid && resLo == 0 && resHi == 0 && !qFlag, "R11 reset", {resHi, resLo}, 64'd0);

    doOp(3'd0, 1'b1, 1'b0, 32'h20000001, 32'h20000001, 32'd4, 32'd0, 1'b0, "R1 example");
    chk(resLo == 32'h00002004, "R1 literal", 64'(resLo), 64'h2004);
    doOp(3'd0, 1'b0, 1'b1, 32'h0000ffff, 32'h80000000, 32'd0, 32'd0, 1'b0, "R1 neg");
    doOp(3'd1, 1'b0, 1'b0, 32'h00000001, 32'h00000001, 32'hffffffff, 32'd0, 1'b0, "R2 carry");
    doOp(3'd1, 1'b0, 1'b0, 32'h0000ffff, 32'h00000001, 32'd0, 32'd0, 1'b0, "R2 negext");
    doOp(3'd4, 1'b0, 1'b0, 32'h80000000, 32'h00008000, 32'd0, 32'd0, 1'b0, "R5 extreme");
    chk(resLo == 32'h40000000, "R5 literal", 64'(resLo), 64'h40000000);
    doOp(3'd3, 1'b1, 1'b1, 32'h80000000, 32'h80000000, 32'd0, 32'd0, 1'b0, "R4 R9 minmin");
    doOp(3'd2, 1'b0, 1'b1, 32'h7fffffff, 32'h7fff0000, 32'h7fffffff, 32'd0, 1'b0, "R3 R8 ovf");
    chk(qFlag == 1'b1, "R8 set", 64'(qFlag), 64'd1);
    doOp(3'd5, 1'b0, 1'b0, 32'h1234, 32'h5678, 32'd9, 32'd9, 1'b0, "R6 op5");
    doOp(3'd7, 1'b1, 1'b1, 32'hffffffff, 32'hffffffff, 32'd1, 32'd1, 1'b1, "R6 op7 clr");
    chk(qFlag == 1'b0, "R10 clear", 64'(qFlag), 64'd0);
    doOp(3'd0, 1'b0, 1'b0, 32'h00007fff, 32'h00007fff, 32'h7fffffff, 32'd0, 1'b0, "R8 acc16 ovf");
    doOp(3'd0, 1'b0, 1'b0, 32'h00007fff, 32'h00007fff, 32'h7fffffff, 32'd0, 1'b1, "R10 clr+ovf");
    chk(qFlag == 1'b1, "R10 set wins", 64'(qFlag), 64'd1);
    @(negedge clk);
    chk(!outValid && resLo == lastLo && qFlag, "R7 hold", 64'(resLo), 64'(lastLo));
    doOp(3'd3, 1'b0, 1'b0, 32'd0, 32'd0, 32'd0, 32'd0, 1'b1, "R10 clr");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 5));
      doOp(op, 1'($urandom), 1'($urandom), $urandom, $urandom, $urandom, $urandom,
           ($urandom_range(0, 7) == 0), "rand R1 R2 R3 R4 R5");
      if (($urandom & 3) == 0) @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule